// File: doc/BRIEF.md
# Three-Bank Masked Interrupt Controller

This controller gathers 96 interrupt sources into three 32-bit banks. The first two banks are live level inputs, called the low main bank and the high main bank. The third bank is a latched general-purpose bank. Every bank has its own enable mask.

The general-purpose bank does not reach the processor directly. It is folded into four summary positions of the high main bank, one position for each group of eight sources. The two main banks are also filtered by fixed qualifier patterns, so only wired positions can raise an interrupt.

A small word-wide register port reads the causes and masks and writes them. Through the same port the processor reads a "next source" word. A separate single-bit port turns one source on or off without rewriting a whole mask. The processor sees one registered interrupt line.

Top module: `tri_bank_irq_ctrl`

## Requirements
- R1: Source numbers 0 to 31 are low-bank bits, 32 to 63 are high-bank bits (number minus 32), and 64 to 95 are general-purpose bits (number minus 64). The next-source word at address 6 reports a pending source by this number in its bits [6:0], with its upper bits zero.
- R2: A source is pending only when both its cause bit and its mask bit are 1. After reset the low mask is 0, the high mask is 0x0F000000, the general-purpose mask is 0 and the general-purpose cause is 0.
- R3: Only low-bank positions in 0x3DFFFFFE and high-bank positions in 0x0F000DB7 can become pending.
- R4: High-bank bit 24+k is the OR of the pending general-purpose bits 8k to 8k+7, for k = 0 to 3. The raw high inputs at bits 24 to 27 are ignored. Reading the high cause (address 1) shows the summary bits in those positions.
- R5: The next source is the lowest pending low-bank source. If there is none, it is the lowest pending high-bank source. If that high source is a summary bit, the next source is instead the lowest pending general-purpose source.
- R6: When no qualified source is pending, the next-source word reads 127.
- R7: A general-purpose cause bit is set in the cycle after its input is 1. A write to address 2 clears every cause bit written as 0 and keeps every cause bit written as 1.
- R8: When a source input of 1 and a clearing write hit the same general-purpose cause bit in the same cycle, the bit ends up set.
- R9: A single-bit operation on op_src changes exactly one mask bit to the value of op_enable. op_src[6:5] selects the bank (00 low, 01 high, 10 general-purpose, 11 none) and op_src[4:0] selects the bit. If a whole-mask write occurs in the same cycle, the operation is applied on top of the written value.
- R10: cpu_irq equals, one clock later, the OR of all pending qualified low-bank and high-bank bits. It is 0 after reset.
- R11: Register addresses are: 0 low cause (read only), 1 high cause (read only), 2 general-purpose cause, 3 low mask, 4 high mask, 5 general-purpose mask, 6 next source (read only). Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_src | input | 32 | Low main bank source levels |
| hi_src | input | 32 | High main bank source levels |
| gpp_src | input | 32 | General-purpose source set requests |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data |
| op_valid | input | 1 | Single-bit mask operation strobe |
| op_enable | input | 1 | Mask bit value applied by the operation |
| op_src | input | 7 | Source number targeted by the operation |
| cpu_irq | output | 1 | Registered interrupt line to the processor |

## Verification
A vector table applies a range of low-bank and high-bank cause and mask patterns:
- patterns that hit only unqualified positions, which separate the qualifier filters from the masks;
- overlapping low and high sources, which show the low-first order;
- raw inputs at the summary positions, which show that those inputs are ignored.

Directed sequences cover the general-purpose bank:
- they show a masked cause being held but not reported;
- they walk from a summary bit down into the general-purpose bank;
- they compare two general-purpose sources to confirm the lowest is chosen;
- they mask the summary itself.

Write-zero clears, set-versus-clear collisions, bank-3 operations and combined write-plus-operation cycles test the update rules at their edges.

// File: rtl/tri_bank_irq_ctrl.sv
module tri_bank_irq_ctrl #(
  parameter logic [31:0] LO_QUAL     = 32'h3DFF_FFFE,
  parameter logic [31:0] HI_QUAL     = 32'h0F00_0DB7,
  parameter logic [31:0] HI_MASK_RST = 32'h0F00_0000,
  parameter int          SUM_LSB     = 24,
  parameter logic [6:0]  SPURIOUS    = 7'h7F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lo_src,
  input  logic [31:0] hi_src,
  input  logic [31:0] gpp_src,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        op_valid,
  input  logic        op_enable,
  input  logic [6:0]  op_src,
  output logic        cpu_irq
);
  localparam logic [2:0] A_LO_CAUSE = 3'd0, A_HI_CAUSE = 3'd1, A_GP_CAUSE = 3'd2,
                         A_LO_MASK  = 3'd3, A_HI_MASK  = 3'd4, A_GP_MASK  = 3'd5,
                         A_NEXT     = 3'd6;
  localparam logic [31:0] SUM_FIELD = 32'hF << SUM_LSB;

  logic [31:0] lo_mask, hi_mask, gpp_mask, gpp_cause;
  logic [31:0] lo_mask_d, hi_mask_d, gpp_mask_d;
  logic [31:0] gpp_pend, hi_cause, lo_q, hi_q;
  logic [3:0]  summary;
  logic [5:0]  lo_f, hi_f, gp_f;
  logic [6:0]  next_src;

  function automatic logic [5:0] first_set(input logic [31:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) r = {1'b1, 5'(i)};
    return r;
  endfunction

  assign gpp_pend = gpp_cause & gpp_mask;

  always_comb
    for (int k = 0; k < 4; k++) summary[k] = |gpp_pend[8*k +: 8];

  assign hi_cause = (hi_src & ~SUM_FIELD) | ({28'd0, summary} << SUM_LSB);
  assign lo_q     = lo_src & LO_QUAL & lo_mask;
  assign hi_q     = hi_cause & HI_QUAL & hi_mask;
  assign lo_f     = first_set(lo_q);
  assign hi_f     = first_set(hi_q);
  assign gp_f     = first_set(gpp_pend);

  always_comb begin
    next_src = SPURIOUS;
    if (lo_f[5])
      next_src = {2'b00, lo_f[4:0]};
    else if (hi_f[5]) begin
      if (hi_f[4:0] >= 5'(SUM_LSB) && hi_f[4:0] < 5'(SUM_LSB + 4))
        next_src = gp_f[5] ? {2'b10, gp_f[4:0]} : SPURIOUS;
      else
        next_src = {2'b01, hi_f[4:0]};
    end
  end

  always_comb begin
    lo_mask_d  = (wr_en && addr == A_LO_MASK) ? wdata : lo_mask;
    hi_mask_d  = (wr_en && addr == A_HI_MASK) ? wdata : hi_mask;
    gpp_mask_d = (wr_en && addr == A_GP_MASK) ? wdata : gpp_mask;
    if (op_valid)
      case (op_src[6:5])
        2'b00:   lo_mask_d[op_src[4:0]]  = op_enable;
        2'b01:   hi_mask_d[op_src[4:0]]  = op_enable;
        2'b10:   gpp_mask_d[op_src[4:0]] = op_enable;
        default: ;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_mask   <= '0;
      hi_mask   <= HI_MASK_RST;
      gpp_mask  <= '0;
      gpp_cause <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      lo_mask   <= lo_mask_d;
      hi_mask   <= hi_mask_d;
      gpp_mask  <= gpp_mask_d;
      gpp_cause <= ((wr_en && addr == A_GP_CAUSE) ? (gpp_cause & wdata) : gpp_cause) | gpp_src;
      cpu_irq   <= |(lo_q | hi_q);
    end
  end

  always_comb
    case (addr)
      A_LO_CAUSE: rdata = lo_src;
      A_HI_CAUSE: rdata = hi_cause;
      A_GP_CAUSE: rdata = gpp_cause;
      A_LO_MASK:  rdata = lo_mask;
      A_HI_MASK:  rdata = hi_mask;
      A_GP_MASK:  rdata = gpp_mask;
      A_NEXT:     rdata = {25'd0, next_src};
      default:    rdata = '0;
    endcase
endmodule

// File: rtl/irq_ctrl_checks.sv
module irq_ctrl_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] gpp_src,
  input logic [31:0] gpp_cause,
  input logic [31:0] lo_mask,
  input logic [31:0] hi_mask,
  input logic [31:0] gpp_mask,
  input logic [6:0]  next_src,
  input logic        cpu_irq
);
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == $past(next_src != 7'h7F));

  a_r7_w0c_update: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 3'd2) |->
      gpp_cause == (($past(gpp_cause) & $past(wdata)) | $past(gpp_src)));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gpp_cause & $past(gpp_src)) == $past(gpp_src)));

  a_r6_next_range: assert property (@(posedge clk) disable iff (!rst_n)
    next_src == 7'h7F || next_src < 7'd96);

  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_mask == 0 && hi_mask == 0) |-> next_src == 7'h7F);

  a_r9_lo_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr == 3'd3) |-> $countones(lo_mask ^ $past(lo_mask)) <= 1);

  a_r9_hi_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr == 3'd4) |-> $countones(hi_mask ^ $past(hi_mask)) <= 1);

  a_r9_gp_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr == 3'd5) |-> $countones(gpp_mask ^ $past(gpp_mask)) <= 1);
endmodule

bind tri_bank_irq_ctrl irq_ctrl_checks u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .gpp_src(gpp_src), .gpp_cause(gpp_cause), .lo_mask(lo_mask), .hi_mask(hi_mask),
  .gpp_mask(gpp_mask), .next_src(next_src), .cpu_irq(cpu_irq)
);

// File: tb/tb_tri_bank_irq_ctrl.sv
`timescale 1ns/100ps
module tb_tri_bank_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [31:0] lo_src = 0, hi_src = 0, gpp_src = 0, wdata = 0, rdata;
  logic wr_en = 0, op_valid = 0, op_enable = 0, cpu_irq;
  logic [2:0] addr = 0;
  logic [6:0] op_src = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tri_bank_irq_ctrl dut (.*);

  // lo_mask, hi_mask, lo_src, hi_src, expected next source
  localparam logic [134:0] VEC [9] = '{
    {32'hFFFF_FFFF, 32'h0, 32'h0000_0001, 32'h0, 7'd127},
    {32'hFFFF_FFFF, 32'h0, 32'h0000_0006, 32'h0, 7'd1},
    {32'hFFFF_FFFF, 32'h0, 32'h8200_0000, 32'h0, 7'd127},
    {32'h1000_0000, 32'h0, 32'h1000_0000, 32'h0, 7'd28},
    {32'h0, 32'hFFFF_FFFF, 32'h1000_0000, 32'h0000_0008, 7'd127},
    {32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0408, 7'd42},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0100, 32'h0000_0001, 7'd8},
    {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFF00_0000, 7'd127},
    {32'h0, 32'h0000_0800, 32'h0, 32'h0000_0880, 7'd43}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic op(input logic en, input logic [6:0] s);
    @(negedge clk); op_valid = 1; op_enable = en; op_src = s;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic pulse_gpp(input logic [31:0] v);
    @(negedge clk); gpp_src = v;
    @(negedge clk); gpp_src = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd3, d); chk("R2 reset low mask", d, 32'h0);
    rd(3'd4, d); chk("R2 reset high mask", d, 32'h0F00_0000);
    rd(3'd5, d); chk("R2 reset gpp mask", d, 32'h0);
    rd(3'd2, d); chk("R2 reset gpp cause", d, 32'h0);
    rd(3'd6, d); chk("R6 reset next", d, 32'd127);
    chk("R10 reset irq", {31'd0, cpu_irq}, 32'd0);

    for (int i = 0; i < 9; i++) begin
      wr(3'd3, VEC[i][134:103]);
      wr(3'd4, VEC[i][102:71]);
      lo_src = VEC[i][70:39]; hi_src = VEC[i][38:7];
      @(negedge clk);
      rd(3'd6, d); chk("R3 R5 R1 table next", d, {25'd0, VEC[i][6:0]});
      chk("R10 table irq", {31'd0, cpu_irq}, {31'd0, VEC[i][6:0] != 7'd127});
    end
    rd(3'd1, d); chk("R4 R11 high cause hides raw summary inputs", d, 32'h0000_0880);

    wr(3'd3, 0); wr(3'd4, 32'h0F00_0000); lo_src = 0; hi_src = 0;
    pulse_gpp(32'h200);
    rd(3'd2, d); chk("R7 cause latched", d, 32'h200);
    rd(3'd6, d); chk("R2 masked gpp not pending", d, 32'd127);
    op(1, 7'd73);
    rd(3'd5, d); chk("R9 enable gpp 73", d, 32'h200);
    rd(3'd1, d); chk("R4 summary bit 25", d, 32'h0200_0000);
    rd(3'd6, d); chk("R5 descend to gpp", d, 32'd73);
    @(negedge clk); chk("R10 irq from summary", {31'd0, cpu_irq}, 32'd1);
    pulse_gpp(32'h8);
    rd(3'd6, d); chk("R5 masked gpp 67 skipped", d, 32'd73);
    op(1, 7'd67);
    rd(3'd6, d); chk("R5 lowest gpp", d, 32'd67);
    wr(3'd2, 32'hFFFF_FFF7);
    rd(3'd2, d); chk("R7 write zero clears one bit", d, 32'h200);
    rd(3'd6, d); chk("R7 next after clear", d, 32'd73);
    op(0, 7'd57);
    rd(3'd4, d); chk("R9 disable summary 57", d, 32'h0D00_0000);
    rd(3'd6, d); chk("R4 masked summary hides gpp", d, 32'd127);
    op(1, 7'd57);
    lo_src = 32'h4; op(1, 7'd2);
    rd(3'd3, d); chk("R9 enable low 2", d, 32'h4);
    rd(3'd6, d); chk("R5 low before gpp", d, 32'd2);
    op(1, 7'd127);
    rd(3'd3, d); chk("R9 bank3 op low unchanged", d, 32'h4);
    rd(3'd4, d); chk("R9 bank3 op high unchanged", d, 32'h0F00_0000);
    rd(3'd5, d); chk("R9 bank3 op gpp unchanged", d, 32'h208);
    lo_src = 0;
    wr(3'd2, 32'h0);
    @(negedge clk); wr_en = 1; addr = 3'd2; wdata = 0; gpp_src = 32'h200;
    @(negedge clk); wr_en = 0; gpp_src = 0;
    rd(3'd2, d); chk("R8 set wins over clear", d, 32'h200);
    wr(3'd2, 32'h0); hi_src = 32'h0F00_0000;
    rd(3'd1, d); chk("R4 raw summary inputs ignored", d, 32'h0);
    rd(3'd6, d); chk("R4 R6 no pending", d, 32'd127);
    @(negedge clk); wr_en = 1; addr = 3'd3; wdata = 32'h0000_F000;
    op_valid = 1; op_enable = 1; op_src = 7'd1;
    @(negedge clk); wr_en = 0; op_valid = 0;
    rd(3'd3, d); chk("R9 op on top of write", d, 32'h0000_F002);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule